// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block gathers up to 112 interrupt request lines into pending state and picks one line to present to a processor core. Each line is set up as either level-driven or edge-driven. A level line marks itself pending on every cycle its input is high. An edge line is caught from a rising edge that may last only a single clock. Software can also raise any line by writing its number to a trigger word. An unprivileged agent may use that word only after a privileged agent has opened it.

Every line has a 5-bit urgency value, and a smaller value means more urgent. The values are packed four to a 32-bit word, one per byte lane. Only the upper five bits of each byte are kept. Out of the pending, enabled lines that are not already being serviced, the block registers the most urgent one and shows its number and urgency to the core. The core acknowledges that choice, which clears the line's pending bit and marks it in service. A later completion strobe, carrying the line number, ends the service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irqValid is 0, irqId and irqPrio are 0, and every readable word (urgency, enable, mode, pending, control) reads 0.
- R2: The urgency of line N is held in word N/4, byte lane N%4, at bits [8*(N%4)+7 : 8*(N%4)]. Only bits [7:3] of a lane are stored, and bits [2:0] read as 0. A lane is written only when busBe[N%4] is 1.
- R3: The presented line is the candidate with the smallest urgency value. When two candidates have equal urgency, the lower number wins. irqValid, irqId and irqPrio change one clock after the state that decides them. When there is no candidate, irqValid is 0 and irqId and irqPrio are 0.
- R4: A line whose mode bit is 1 (words 36..39, bit N%32 of word 36+N/32) becomes pending on a rising edge of its request, even when the request is high for a single cycle. Holding the request high does not make the line pending again.
- R5: A line whose mode bit is 0 becomes pending on every cycle its request is high. After the request falls and the line is acknowledged, it stays clear.
- R6: A write to word 45 with a line number in bits [8:0] makes that line pending when the number is 0 to 111. A number above 111 is ignored.
- R7: Bit 0 of word 44 opens the trigger word to writes with busPriv=0. Only a write with busPriv=1 can change this bit. A trigger write with busPriv=0 while the bit is 0 has no effect.
- R8: coreAck while irqValid is 1 clears the presented line's pending bit and puts the line in service. A line in service is never presented. coreAck while irqValid is 0 changes nothing.
- R9: coreDone takes the line coreDoneId out of service. If that line is still pending, it can be presented again.
- R10: A line whose enable bit is 0 (words 32..35, bit N%32 of word 32+N/32) is never presented, but its pending bit still sets.
- R11: Pending bits read at words 40..43, bit N%32 of word 40+N/32, and writes to these words are ignored. Enable and mode bits above line 111 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busPriv | input | 1 | 1 when the bus access is privileged |
| busAddr | input | 6 | Word address for register reads and writes |
| busBe | input | 4 | Byte-lane enables for urgency writes |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| irqReq | input | 112 | Interrupt request lines |
| irqValid | output | 1 | A line is being presented |
| irqId | output | 7 | Number of the presented line |
| irqPrio | output | 5 | Urgency of the presented line |
| coreAck | input | 1 | Core takes the presented line |
| coreDone | input | 1 | Core finishes servicing a line |
| coreDoneId | input | 7 | Number of the line being finished |

## Verification
Two pairs of events can land in the same cycle. An acknowledge can arrive while the same line's request is still asserting, and a new edge can arrive on a line that is already in service. The bench provokes the first by holding a level request high across the acknowledge. It provokes the second by pulsing an edge line after it has been acknowledged. In both cases the line must be hidden from the core while its pending bit, read back over the bus, stays set. After coreDone the same line must come back to the core without any new request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_IRQ   = 112;
  localparam int PRIO_W    = 5;
  localparam int LANE_W    = 8;
  localparam int LANES     = 4;
  localparam int DATA_W    = LANE_W * LANES;
  localparam int ADDR_W    = 6;
  localparam int ID_W      = $clog2(NUM_IRQ);
  localparam int TRIG_W    = 9;
  localparam int PRIO_REGS = (NUM_IRQ + LANES - 1) / LANES;
  localparam int BIT_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;

  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] TYPE_BASE = ADDR_W'(36);
  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(40);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(44);
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(45);

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic              prioWr;
    logic              enWr;
    logic              typeWr;
    logic [ADDR_W-1:0] wordIdx;
    logic              trigSet;
    logic [ID_W-1:0]   trigId;
    logic              ackFire;
    logic              doneFire;
    logic [ID_W-1:0]   doneId;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busPriv,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TRIG_W-1:0] trigWord,
  input  logic              coreAck,
  input  logic              irqValid,
  input  logic              coreDone,
  input  logic [ID_W-1:0]   coreDoneId,
  output strobe_t           stb,
  output logic              userTrigEn
);
  localparam logic [TRIG_W-1:0] ID_LIMIT   = TRIG_W'(NUM_IRQ);
  localparam logic [ADDR_W-1:0] PRIO_LIMIT = ADDR_W'(PRIO_REGS);
  localparam logic [ADDR_W-1:0] WORDS      = ADDR_W'(BIT_WORDS);

  logic inEn, inType, trigAllowed;

  always_comb begin
    inEn        = (busAddr >= EN_BASE) && (busAddr < EN_BASE + WORDS);
    inType      = (busAddr >= TYPE_BASE) && (busAddr < TYPE_BASE + WORDS);
    trigAllowed = busPriv || userTrigEn;
    stb         = '0;
    stb.prioWr  = busWrEn && (busAddr < PRIO_LIMIT);
    stb.enWr    = busWrEn && inEn;
    stb.typeWr  = busWrEn && inType;
    if (inEn)        stb.wordIdx = busAddr - EN_BASE;
    else if (inType) stb.wordIdx = busAddr - TYPE_BASE;
    else             stb.wordIdx = busAddr;
    stb.trigSet  = busWrEn && (busAddr == TRIG_ADDR) && trigAllowed
                   && (trigWord < ID_LIMIT);
    stb.trigId   = trigWord[ID_W-1:0];
    stb.ackFire  = coreAck && irqValid;
    stb.doneFire = coreDone;
    stb.doneId   = coreDoneId;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      userTrigEn <= 1'b0;
    else if (busWrEn && busPriv && (busAddr == CFG_ADDR))
      userTrigEn <= trigWord[0];
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [LANES-1:0]   busBe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               userTrigEn,
  input  logic [NUM_IRQ-1:0] irqReq,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqValid,
  output logic [ID_W-1:0]    irqId,
  output logic [PRIO_W-1:0]  irqPrio
);
  logic [PRIO_W-1:0]  prioMem [NUM_IRQ];
  logic [NUM_IRQ-1:0] enBits, pulseBits, pendBits, actBits, candBits;

  // Urgency storage, byte-lane writable, top PRIO_W bits of each lane
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IRQ; i++) prioMem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (stb.prioWr && stb.wordIdx == ADDR_W'(i / LANES) && busBe[i % LANES])
          prioMem[i] <= busWdata[LANE_W*(i % LANES) + LANE_W - 1 -: PRIO_W];
    end
  end

  // Per-line state
  for (genvar g = 0; g < NUM_IRQ; g++) begin : gLine
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(g / DATA_W);
    localparam int                BITP = g % DATA_W;
    localparam logic [ID_W-1:0]   MYID = ID_W'(g);
    logic en, pulse, pend, act, reqPrev, setReq, ackHit, doneHit;

    assign setReq  = (pulse ? (irqReq[g] & ~reqPrev) : irqReq[g])
                   | (stb.trigSet && stb.trigId == MYID);
    assign ackHit  = stb.ackFire && (irqId == MYID);
    assign doneHit = stb.doneFire && (stb.doneId == MYID);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; pulse <= 1'b0; pend <= 1'b0; act <= 1'b0; reqPrev <= 1'b0;
      end else begin
        reqPrev <= irqReq[g];
        if (stb.enWr && stb.wordIdx == WORD)   en    <= busWdata[BITP];
        if (stb.typeWr && stb.wordIdx == WORD) pulse <= busWdata[BITP];
        pend <= setReq | (pend & ~ackHit);
        act  <= ackHit | (act & ~doneHit);
      end
    end

    assign enBits[g]    = en;
    assign pulseBits[g] = pulse;
    assign pendBits[g]  = pend;
    assign actBits[g]   = act;
  end

  assign candBits = pendBits & enBits & ~actBits;

  // Most urgent candidate; scanning downward with <= lets the lower ID win ties
  logic              bestValid;
  logic [ID_W-1:0]   bestId;
  logic [PRIO_W-1:0] bestPrio;

  always_comb begin
    bestValid = 1'b0;
    bestId    = '0;
    bestPrio  = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (candBits[i] && (!bestValid || prioMem[i] <= bestPrio)) begin
        bestValid = 1'b1;
        bestId    = ID_W'(i);
        bestPrio  = prioMem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqId    <= '0;
      irqPrio  <= '0;
    end else begin
      irqValid <= bestValid;
      irqId    <= bestValid ? bestId : '0;
      irqPrio  <= bestValid ? bestPrio : '0;
    end
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (busAddr == ADDR_W'(i / LANES))
        busRdata[LANE_W*(i % LANES) +: LANE_W] = {prioMem[i], {(LANE_W-PRIO_W){1'b0}}};
      if (busAddr == EN_BASE + ADDR_W'(i / DATA_W))   busRdata[i % DATA_W] = enBits[i];
      if (busAddr == TYPE_BASE + ADDR_W'(i / DATA_W)) busRdata[i % DATA_W] = pulseBits[i];
      if (busAddr == PEND_BASE + ADDR_W'(i / DATA_W)) busRdata[i % DATA_W] = pendBits[i];
    end
    if (busAddr == CFG_ADDR) busRdata[0] = userTrigEn;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busPriv,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [LANES-1:0]   busBe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_IRQ-1:0] irqReq,
  output logic               irqValid,
  output logic [ID_W-1:0]    irqId,
  output logic [PRIO_W-1:0]  irqPrio,
  input  logic               coreAck,
  input  logic               coreDone,
  input  logic [ID_W-1:0]    coreDoneId
);
  strobe_t stb;
  logic    userTrigEn;

  irqc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busPriv    (busPriv),
    .busAddr    (busAddr),
    .trigWord   (busWdata[TRIG_W-1:0]),
    .coreAck    (coreAck),
    .irqValid   (irqValid),
    .coreDone   (coreDone),
    .coreDoneId (coreDoneId),
    .stb        (stb),
    .userTrigEn (userTrigEn)
  );

  irqc_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busBe      (busBe),
    .busWdata   (busWdata),
    .busAddr    (busAddr),
    .userTrigEn (userTrigEn),
    .irqReq     (irqReq),
    .busRdata   (busRdata),
    .irqValid   (irqValid),
    .irqId      (irqId),
    .irqPrio    (irqPrio)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqValid,
  input logic [ID_W-1:0]   irqId,
  input logic [PRIO_W-1:0] irqPrio,
  input logic              coreAck
);
  localparam logic [ADDR_W-1:0] PRIO_LIMIT = ADDR_W'(PRIO_REGS);
  localparam logic [ID_W-1:0]   TOP_ID     = ID_W'(NUM_IRQ - 1);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqValid);

  // R2
  prio_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < PRIO_LIMIT) |-> ((busRdata & 32'h0707_0707) == 32'h0));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqId == '0 && irqPrio == '0));

  // R3
  id_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqId <= TOP_ID));

  // R8
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreAck && irqValid) |=> ##1 !(irqValid && irqId == $past(irqId, 2)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic         busPriv = 1'b0;
  logic [5:0]   busAddr = '0;
  logic [3:0]   busBe = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [111:0] irqReq = '0;
  logic         irqValid;
  logic [6:0]   irqId;
  logic [4:0]   irqPrio;
  logic         coreAck = 1'b0;
  logic         coreDone = 1'b0;
  logic [6:0]   coreDoneId = '0;

  int nRun = 0;
  int nFail = 0;

  irq_prio_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        v;
    logic [6:0]  id;
    logic [4:0]  prio;
    string       tag;
  } sel_t;
  sel_t expQ[$];

  // Monitor: compares queued expectations with the presented line
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      sel_t e;
      e = expQ.pop_front();
      nRun++;
      if (irqValid !== e.v || irqId !== e.id || irqPrio !== e.prio) begin
        nFail++;
        $display("FAIL %s: got v=%0b id=%0d prio=%0d, expected v=%0b id=%0d prio=%0d",
                 e.tag, irqValid, irqId, irqPrio, e.v, e.id, e.prio);
      end
    end
  end

  task automatic expectSel(input logic v, input int id, input int prio, input string tag);
    @(posedge clk);
    expQ.push_back('{v: v, id: 7'(id), prio: 5'(prio), tag: tag});
    @(negedge clk);
    #1;
  endtask

  task automatic checkVal(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h, expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [31:0] data, input logic [3:0] be,
                          input logic priv);
    @(negedge clk);
    busAddr = 6'(addr); busWdata = data; busBe = be; busPriv = priv; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busPriv = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = 6'(addr);
    #1;
    data = busRdata;
  endtask

  task automatic readCheck(input int addr, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    busRead(addr, d);
    checkVal(d, exp, tag);
  endtask

  task automatic pendBit(input int line, input logic exp, input string tag);
    logic [31:0] d;
    busRead(40 + line / 32, d);
    checkVal({31'b0, d[line % 32]}, {31'b0, exp}, tag);
  endtask

  task automatic trig(input int id, input logic priv);
    busWrite(45, 32'(id), 4'hF, priv);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irqReq[line] = 1'b1;
    @(negedge clk); irqReq[line] = 1'b0;
  endtask

  task automatic ackIrq();
    @(negedge clk); coreAck = 1'b1;
    @(negedge clk); coreAck = 1'b0;
  endtask

  task automatic doneIrq(input int id);
    @(negedge clk); coreDone = 1'b1; coreDoneId = 7'(id);
    @(negedge clk); coreDone = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectSel(1'b0, 0, 0, "R1 idle after reset");
    readCheck(0, 32'h0, "R1 urgency word 0");
    readCheck(32, 32'h0, "R1 enable word");
    readCheck(40, 32'h0, "R1 pending word");
    readCheck(44, 32'h0, "R1 control word");

    // R2 lane placement, byte enables, low bits dropped
    busWrite(1, 32'hFFFF_FFFF, 4'b0101, 1'b1);
    readCheck(1, 32'h00F8_00F8, "R2 byte enables");
    busWrite(27, 32'h1234_5678, 4'hF, 1'b1);
    readCheck(27, 32'h1030_5078, "R2 upper five bits kept");

    // R11 enable all, pad bits zero, pending read-only
    for (int w = 32; w < 36; w++) busWrite(w, 32'hFFFF_FFFF, 4'hF, 1'b1);
    readCheck(35, 32'h0000_FFFF, "R11 enable pad bits");
    busWrite(40, 32'hFFFF_FFFF, 4'hF, 1'b1);
    readCheck(40, 32'h0, "R11 pending write ignored");
    expectSel(1'b0, 0, 0, "R11 no line after pending write");

    // R4 single-cycle pulse on an edge line
    busWrite(37, 32'h0000_0100, 4'hF, 1'b1);
    readCheck(37, 32'h0000_0100, "R4 mode bit");
    pulse(40);
    expectSel(1'b1, 40, 0, "R4 single-cycle pulse");
    pendBit(40, 1'b1, "R4 pending set");

    // R8 acknowledge; new edge while in service stays hidden
    ackIrq();
    expectSel(1'b0, 0, 0, "R8 acked line hidden");
    pendBit(40, 1'b0, "R8 pending cleared");
    pulse(40);
    expectSel(1'b0, 0, 0, "R8 in-service line hidden");
    pendBit(40, 1'b1, "R8 pending while in service");

    // R9 completion re-presents a pending line
    doneIrq(40);
    expectSel(1'b1, 40, 0, "R9 re-presented after done");
    ackIrq();
    doneIrq(40);
    expectSel(1'b0, 0, 0, "R9 idle");

    // R3 urgency order: 110 prio 6, 109 prio 10, 4 prio 31
    trig(110, 1'b1); trig(109, 1'b1); trig(4, 1'b1);
    expectSel(1'b1, 110, 6, "R3 most urgent");
    ackIrq();
    expectSel(1'b1, 109, 10, "R3 second");
    ackIrq();
    expectSel(1'b1, 4, 31, "R3 least urgent");
    ackIrq();
    expectSel(1'b0, 0, 0, "R3 all in service");
    doneIrq(110); doneIrq(109); doneIrq(4);

    // R3 tie goes to lower number
    trig(20, 1'b1); trig(10, 1'b1);
    expectSel(1'b1, 10, 0, "R3 tie lower id");
    ackIrq();
    expectSel(1'b1, 20, 0, "R3 tie second");
    ackIrq();
    doneIrq(10); doneIrq(20);
    expectSel(1'b0, 0, 0, "R3 idle after tie");

    // R6 out-of-range numbers ignored, top number accepted
    trig(112, 1'b1); trig(511, 1'b1);
    readCheck(43, 32'h0, "R6 out-of-range ignored");
    expectSel(1'b0, 0, 0, "R6 nothing presented");
    trig(111, 1'b1);
    expectSel(1'b1, 111, 2, "R6 top id");
    ackIrq(); doneIrq(111);

    // R7 privilege gating
    trig(5, 1'b0);
    expectSel(1'b0, 0, 0, "R7 unprivileged trigger ignored");
    readCheck(40, 32'h0, "R7 pending untouched");
    busWrite(44, 32'h1, 4'hF, 1'b0);
    readCheck(44, 32'h0, "R7 unprivileged control write ignored");
    busWrite(44, 32'h1, 4'hF, 1'b1);
    readCheck(44, 32'h1, "R7 privileged control write");
    trig(5, 1'b0);
    expectSel(1'b1, 5, 0, "R7 unprivileged trigger opened");
    ackIrq(); doneIrq(5);
    busWrite(44, 32'h0, 4'hF, 1'b1);

    // R10 disabled line stays pending but hidden
    busWrite(32, 32'hFFFF_FF7F, 4'hF, 1'b1);
    trig(7, 1'b1);
    expectSel(1'b0, 0, 0, "R10 disabled hidden");
    pendBit(7, 1'b1, "R10 pending kept");
    ackIrq();
    pendBit(7, 1'b1, "R8 ack while idle ignored");
    busWrite(32, 32'hFFFF_FFFF, 4'hF, 1'b1);
    expectSel(1'b1, 7, 0, "R10 presented after enable");
    ackIrq(); doneIrq(7);

    // R5 level line held across acknowledge
    @(negedge clk); irqReq[50] = 1'b1;
    @(negedge clk);
    expectSel(1'b1, 50, 0, "R5 level presented");
    ackIrq();
    expectSel(1'b0, 0, 0, "R5 in service hidden");
    pendBit(50, 1'b1, "R5 held level re-pends");
    @(negedge clk); irqReq[50] = 1'b0;
    doneIrq(50);
    expectSel(1'b1, 50, 0, "R5 latched after release");
    ackIrq();
    doneIrq(50);
    expectSel(1'b0, 0, 0, "R5 no re-pend after release");
    pendBit(50, 1'b0, "R5 pending clear");

    // R4 held edge request pends only once
    @(negedge clk); irqReq[40] = 1'b1;
    repeat (5) @(negedge clk);
    expectSel(1'b1, 40, 0, "R4 held edge presented");
    ackIrq();
    doneIrq(40);
    expectSel(1'b0, 0, 0, "R4 held edge no re-pend");
    @(negedge clk); irqReq[40] = 1'b0;

    summary();
    $finish;
  end
endmodule